// File: doc/BRIEF.md
# Gapped Digital Video Image-Port Formatter

This block sits between a picture scaler and an 8-bit parallel video output pin group. The scaler delivers bytes on a continuous clock. Each byte carries a valid flag, and a line flag marks the span of a line that carries data. The formatter turns this into a BT.656-style byte stream and drives a data-qualifier output with it. Every line with data is wrapped in a start-of-active-video code (SAV) and an end-of-active-video code (EAV). Reserved values are cleaned out of the picture payload. Every cycle with nothing to send carries the fill byte 00h with the qualifier inactive. Gaps in the input stay at their positions, so the Cb-Y-Cr-Y phase does not follow any fixed clock divider.

A line flagged as ancillary is handled differently. It is sent as a packet: the 00h FFh FFh lead-in, then its data bytes. It gets no SAV and no EAV. The data is either passed unchanged or recoded so that 00h and FFh never appear. Raw VBI sample lines use the video path, so they are framed and cleaned the same way as picture lines. The qualifier, horizontal reference and vertical reference outputs each have their own polarity bit.

Usage rules for the upstream block:
- Keep `in_line` low for at least 8 cycles between two lines.
- Hold `in_anc`, `in_fld` and `in_vblk` constant while `in_line` is high.
- Keep `in_vld` high for the whole of an ancillary line.
- Keep the range limits between 01h and FEh, with `cfg_lim_lo` not above `cfg_lim_hi`.

Top module: `img_port_fmt`

## Requirements
- R1: While reset is held, `out_data` is 00h, and `out_dq`, `out_href` and `out_vref` sit at their inactive levels (raw 0 XOR the matching invert bit).
- R2: If cycle n is the first cycle with `in_line` high and `in_anc` low, then cycles n, n+1, n+2 and n+3 carry FFh, 00h, 00h and XY with H=0, back to back and qualified. F and V are sampled in cycle n.
- R3: If cycle j is the first low cycle after a video line, then cycles j+4 to j+7 carry FFh, 00h, 00h and XY with H=1, qualified. F and V are those of the line.
- R4: The XY code word is laid out as bit7=1, bit6=F, bit5=V, bit4=H, bit3=V^H, bit2=F^H, bit1=F^V, bit0=F^V^H.
- R5: While `in_line` is low, `in_vld` and `in_data` have no effect, and no codes are produced for such cycles.
- R6: A video byte with `in_vld` high in cycle i is sent qualified in cycle i+4. Every cycle that carries no code and no payload sends 00h with the qualifier inactive, so input gaps reappear at the same positions.
- R7: In video and raw-VBI payload, 00h is sent as 01h and FFh is sent as FEh. Other values are sent unchanged.
- R8: With `cfg_lim_en` high, each video payload byte is clamped to the range `cfg_lim_lo` to `cfg_lim_hi`, after the R7 substitution.
- R9: If cycle n is the first cycle of a line with `in_anc` high, then cycles n, n+1 and n+2 carry 00h, FFh and FFh. A data byte from cycle i follows in cycle i+3 with no empty cycles in between. With `cfg_anc_recode` low the data bytes pass unchanged.
- R10: With `cfg_anc_recode` high, ancillary data byte 00h is sent as 03h and FFh is sent as FCh. Other values are sent unchanged.
- R11: `out_dq` is the qualifier XOR `cfg_dq_inv`. `out_vref` is the V value of the most recent line start XOR `cfg_vref_inv`.
- R12: In cycle k, `out_href` equals (`in_line` AND NOT `in_anc`, both taken from cycle k-4) XOR `cfg_href_inv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Continuous port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Byte from the scaler |
| in_vld | input | 1 | `in_data` holds a byte to send |
| in_line | input | 1 | Current line carries data |
| in_anc | input | 1 | Current line is an ancillary packet |
| in_fld | input | 1 | Field bit F for the current line |
| in_vblk | input | 1 | Vertical blanking bit V for the current line |
| cfg_anc_recode | input | 1 | Recode 00h and FFh in ancillary data |
| cfg_lim_en | input | 1 | Enable payload range clamp |
| cfg_lim_lo | input | 8 | Lowest payload value allowed |
| cfg_lim_hi | input | 8 | Highest payload value allowed |
| cfg_dq_inv | input | 1 | Invert qualifier output |
| cfg_href_inv | input | 1 | Invert horizontal reference |
| cfg_vref_inv | input | 1 | Invert vertical reference |
| out_data | output | 8 | Formatted output byte |
| out_dq | output | 1 | Data qualifier |
| out_href | output | 1 | Horizontal reference |
| out_vref | output | 1 | Vertical reference |

## Verification
Each result appears a fixed number of cycles after the input that causes it. A line start produces its first code byte after the very next edge. A video payload byte, the EAV that follows a line's end, and the horizontal reference each lag their input by four cycles. An ancillary data byte lags by three cycles. The vertical reference changes at the edge that sees a line start. The bench plays a prepared stimulus array, records every output in the half-cycle after each edge under the same cycle index, and then computes the expected value for cycle k from stimulus entries k, k-3, k-4 and earlier, using exactly those lags.

// File: rtl/ipf_pkg.sv
package ipf_pkg;
  localparam int BYTE_W      = 8;
  localparam int TRC_LEN     = 4;
  localparam int ANC_HDR_LEN = 3;
  localparam int VID_LAT     = TRC_LEN;
  localparam int ANC_LAT     = ANC_HDR_LEN;
  localparam int IDX_W       = $clog2(TRC_LEN);

  typedef logic [BYTE_W-1:0] pix_t;
  typedef logic [IDX_W-1:0]  cidx_t;

  typedef struct packed {
    logic line;
    logic kind;
    logic vld;
    pix_t data;
  } beat_t;

  typedef enum logic [1:0] {CT_SAV, CT_EAV, CT_HDR} code_t;
  typedef enum logic [1:0] {TAG_FILL, TAG_CODE, TAG_VID, TAG_ANC} tag_t;

  localparam pix_t FILL_CODE = '0;
  localparam pix_t ALL_ONES  = '1;

  // Fourth byte of a timing reference code, protection bits included.
  function automatic pix_t trc_word(logic f, logic v, logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic cidx_t code_last(code_t t);
    return (t == CT_HDR) ? cidx_t'(ANC_HDR_LEN - 1) : cidx_t'(TRC_LEN - 1);
  endfunction

  function automatic pix_t code_byte(code_t t, cidx_t idx, pix_t xy);
    pix_t b;
    if (t == CT_HDR) begin
      b = (idx == '0) ? FILL_CODE : ALL_ONES;
    end else begin
      if (idx == '0)                          b = ALL_ONES;
      else if (idx == cidx_t'(TRC_LEN - 1))   b = xy;
      else                                    b = FILL_CODE;
    end
    return b;
  endfunction

  // Video / raw-VBI payload: reserved values nudged inward, then optional clamp.
  function automatic pix_t vid_clean(pix_t b, logic lim_en, pix_t lo, pix_t hi);
    pix_t x;
    if (b == FILL_CODE)     x = pix_t'(1);
    else if (b == ALL_ONES) x = ALL_ONES - pix_t'(1);
    else                    x = b;
    if (lim_en) begin
      if (x < lo) x = lo;
      if (x > hi) x = hi;
    end
    return x;
  endfunction

  // Ancillary payload: direct, or recoded to even-parity neighbours.
  function automatic pix_t anc_map(pix_t b, logic recode);
    pix_t x;
    x = b;
    if (recode) begin
      if (b == FILL_CODE)     x = pix_t'(3);
      else if (b == ALL_ONES) x = ALL_ONES - pix_t'(3);
    end
    return x;
  endfunction
endpackage

// File: rtl/ipf_delay_line.sv
module ipf_delay_line
  import ipf_pkg::*;
#(
  parameter int DEPTH = VID_LAT
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  beat_t                   d_in,
  output beat_t [DEPTH-1:0]       taps
);
  beat_t stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d_in;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
    assign taps[i] = stg[i];
  end
endmodule

// File: rtl/ipf_code_seq.sv
module ipf_code_seq
  import ipf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic st_sav,
  input  logic st_eav,
  input  logic st_hdr,
  input  logic f_q,
  input  logic v_q,
  output logic code_on,
  output pix_t code_out,
  output logic busy
);
  cidx_t idx_q;
  code_t type_q;
  logic  any_start;
  code_t start_type;

  assign busy      = (idx_q != '0);
  assign any_start = st_sav | st_eav | st_hdr;

  always_comb begin
    if (st_sav)      start_type = CT_SAV;
    else if (st_eav) start_type = CT_EAV;
    else             start_type = CT_HDR;
  end

  always_comb begin
    code_on  = 1'b1;
    code_out = FILL_CODE;
    if (any_start) begin
      code_out = code_byte(start_type, '0, FILL_CODE);
    end else if (busy) begin
      code_out = code_byte(type_q, idx_q, trc_word(f_q, v_q, type_q == CT_EAV));
    end else begin
      code_on = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      type_q <= CT_SAV;
    end else if (any_start) begin
      idx_q  <= cidx_t'(1);
      type_q <= start_type;
    end else if (busy) begin
      idx_q <= (idx_q == code_last(type_q)) ? '0 : idx_q + cidx_t'(1);
    end
  end
endmodule

// File: rtl/ipf_out_reg.sv
module ipf_out_reg
  import ipf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic code_on,
  input  pix_t code_out,
  input  logic vid_pay,
  input  pix_t vid_data,
  input  logic anc_pay,
  input  pix_t anc_data,
  input  logic anc_recode,
  input  logic lim_en,
  input  pix_t lim_lo,
  input  pix_t lim_hi,
  output pix_t out_q,
  output tag_t tag_q
);
  pix_t nxt_b;
  tag_t nxt_t;

  always_comb begin
    nxt_b = FILL_CODE;
    nxt_t = TAG_FILL;
    if (code_on) begin
      nxt_b = code_out;
      nxt_t = TAG_CODE;
    end else if (vid_pay) begin
      nxt_b = vid_clean(vid_data, lim_en, lim_lo, lim_hi);
      nxt_t = TAG_VID;
    end else if (anc_pay) begin
      nxt_b = anc_map(anc_data, anc_recode);
      nxt_t = TAG_ANC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= FILL_CODE;
      tag_q <= TAG_FILL;
    end else begin
      out_q <= nxt_b;
      tag_q <= nxt_t;
    end
  end
endmodule

// File: rtl/img_port_fmt.sv
module img_port_fmt
  import ipf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_vld,
  input  logic       in_line,
  input  logic       in_anc,
  input  logic       in_fld,
  input  logic       in_vblk,
  input  logic       cfg_anc_recode,
  input  logic       cfg_lim_en,
  input  logic [7:0] cfg_lim_lo,
  input  logic [7:0] cfg_lim_hi,
  input  logic       cfg_dq_inv,
  input  logic       cfg_href_inv,
  input  logic       cfg_vref_inv,
  output logic [7:0] out_data,
  output logic       out_dq,
  output logic       out_href,
  output logic       out_vref
);
  beat_t                 in_beat;
  beat_t [VID_LAT-1:0]   taps;
  beat_t                 vid_b;
  beat_t                 anc_b;

  logic sav_start, eav_start, hdr_start, line_rise;
  logic vid_line_tap, vid_pay, anc_pay;
  logic win_q, f_q, v_q;
  logic code_on, code_busy;
  pix_t code_out, out_q;
  tag_t tag_q;

  assign in_beat = '{line: in_line, kind: in_anc, vld: in_vld, data: in_data};

  ipf_delay_line #(.DEPTH(VID_LAT)) u_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (in_beat),
    .taps (taps)
  );

  assign vid_b = taps[VID_LAT-1];
  assign anc_b = taps[ANC_LAT-1];

  // Named events used by the sequencer and the checker.
  assign line_rise    = in_line & ~taps[0].line;
  assign sav_start    = line_rise & ~in_anc;
  assign hdr_start    = line_rise & in_anc;
  assign vid_line_tap = vid_b.line & ~vid_b.kind;
  assign eav_start    = win_q & ~vid_line_tap;
  assign vid_pay      = vid_line_tap & vid_b.vld;
  assign anc_pay      = anc_b.line & anc_b.kind & anc_b.vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      f_q   <= 1'b0;
      v_q   <= 1'b0;
    end else begin
      win_q <= vid_line_tap;
      if (line_rise) begin
        f_q <= in_fld;
        v_q <= in_vblk;
      end
    end
  end

  ipf_code_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .st_sav  (sav_start),
    .st_eav  (eav_start),
    .st_hdr  (hdr_start),
    .f_q     (f_q),
    .v_q     (v_q),
    .code_on (code_on),
    .code_out(code_out),
    .busy    (code_busy)
  );

  ipf_out_reg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_on   (code_on),
    .code_out  (code_out),
    .vid_pay   (vid_pay),
    .vid_data  (vid_b.data),
    .anc_pay   (anc_pay),
    .anc_data  (anc_b.data),
    .anc_recode(cfg_anc_recode),
    .lim_en    (cfg_lim_en),
    .lim_lo    (cfg_lim_lo),
    .lim_hi    (cfg_lim_hi),
    .out_q     (out_q),
    .tag_q     (tag_q)
  );

  assign out_data = out_q;
  assign out_dq   = (tag_q != TAG_FILL) ^ cfg_dq_inv;
  assign out_href = win_q ^ cfg_href_inv;
  assign out_vref = v_q ^ cfg_vref_inv;
endmodule

// File: rtl/img_port_fmt_chk.sv
module img_port_fmt_chk
  import ipf_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic sav_start,
  input logic eav_start,
  input logic hdr_start,
  input logic code_busy,
  input tag_t tag_q,
  input pix_t out_q,
  input logic cfg_anc_recode,
  input logic cfg_lim_en,
  input pix_t cfg_lim_lo,
  input pix_t cfg_lim_hi
);
  p_sav_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sav_start |=> (tag_q == TAG_CODE && out_q == 8'hFF));

  p_code_gapless_r2: assert property (@(posedge clk) disable iff (!rst_n)
    code_busy |=> (tag_q == TAG_CODE));

  p_eav_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eav_start |=> (tag_q == TAG_CODE && out_q == 8'hFF));

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    code_busy |-> !(sav_start || eav_start || hdr_start));

  p_prot_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_q == TAG_CODE && out_q[7] && out_q != 8'hFF) |->
      (out_q[3] == (out_q[5] ^ out_q[4]) && out_q[2] == (out_q[6] ^ out_q[4]) &&
       out_q[1] == (out_q[6] ^ out_q[5]) && out_q[0] == (out_q[6] ^ out_q[5] ^ out_q[4])));

  p_fill_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_q == TAG_FILL) |-> (out_q == 8'h00));

  p_vid_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_q == TAG_VID) |-> (out_q != 8'h00 && out_q != 8'hFF));

  p_lim_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_q == TAG_VID && $past(cfg_lim_en) && $past(cfg_lim_lo) <= $past(cfg_lim_hi)) |->
      (out_q >= $past(cfg_lim_lo) && out_q <= $past(cfg_lim_hi)));

  p_hdr_lead_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_start |=> (tag_q == TAG_CODE && out_q == 8'h00));

  p_anc_recode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_q == TAG_ANC && $past(cfg_anc_recode)) |-> (out_q != 8'h00 && out_q != 8'hFF));
endmodule

bind img_port_fmt img_port_fmt_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sav_start     (sav_start),
  .eav_start     (eav_start),
  .hdr_start     (hdr_start),
  .code_busy     (code_busy),
  .tag_q         (tag_q),
  .out_q         (out_q),
  .cfg_anc_recode(cfg_anc_recode),
  .cfg_lim_en    (cfg_lim_en),
  .cfg_lim_lo    (cfg_lim_lo),
  .cfg_lim_hi    (cfg_lim_hi)
);

// File: tb/img_port_fmt_tb_top.sv
module img_port_fmt_tb_top;
  localparam int N = 900;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic in_vld = 1'b0, in_line = 1'b0, in_anc = 1'b0, in_fld = 1'b0, in_vblk = 1'b0;
  logic cfg_anc_recode = 1'b0, cfg_lim_en = 1'b0;
  logic [7:0] cfg_lim_lo = 8'h10, cfg_lim_hi = 8'hEB;
  logic cfg_dq_inv = 1'b0, cfg_href_inv = 1'b0, cfg_vref_inv = 1'b0;
  logic [7:0] out_data;
  logic out_dq, out_href, out_vref;

  int checks = 0;
  int errors = 0;
  int unsigned seed;

  bit         s_line [N];
  bit         s_kind [N];
  bit         s_vld  [N];
  bit         s_f    [N];
  bit         s_v    [N];
  logic [7:0] s_data [N];
  logic [7:0] o_b    [N];
  bit         o_dq   [N];
  bit         o_h    [N];
  bit         o_vr   [N];

  always #5 clk = ~clk;

  img_port_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_vld(in_vld), .in_line(in_line),
    .in_anc(in_anc), .in_fld(in_fld), .in_vblk(in_vblk), .cfg_anc_recode(cfg_anc_recode),
    .cfg_lim_en(cfg_lim_en), .cfg_lim_lo(cfg_lim_lo), .cfg_lim_hi(cfg_lim_hi),
    .cfg_dq_inv(cfg_dq_inv), .cfg_href_inv(cfg_href_inv), .cfg_vref_inv(cfg_vref_inv),
    .out_data(out_data), .out_dq(out_dq), .out_href(out_href), .out_vref(out_vref)
  );

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return (seed >> 16) & 32'h7FFF;
  endfunction

  function automatic logic [7:0] rbyte();
    int unsigned sel;
    sel = rnd() % 10;
    case (sel)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h01;
      3: return 8'hFE;
      4: return cfg_lim_lo - 8'd1;
      5: return cfg_lim_hi + 8'd1;
      default: return 8'(rnd());
    endcase
  endfunction

  // Expected arithmetic restated from the requirements.
  function automatic logic [7:0] tb_xy(bit f, bit v, bit h);
    bit p3, p2, p1, p0;
    p3 = v ^ h; p2 = f ^ h; p1 = f ^ v; p0 = f ^ v ^ h;
    return {1'b1, f, v, h, p3, p2, p1, p0};
  endfunction

  function automatic logic [7:0] tb_vid(logic [7:0] b);
    logic [7:0] x;
    x = (b == 8'h00) ? 8'h01 : (b == 8'hFF) ? 8'hFE : b;
    if (cfg_lim_en) begin
      if (x < cfg_lim_lo) x = cfg_lim_lo;
      else if (x > cfg_lim_hi) x = cfg_lim_hi;
    end
    return x;
  endfunction

  function automatic logic [7:0] tb_anc(logic [7:0] b);
    if (!cfg_anc_recode) return b;
    return (b == 8'h00) ? 8'h03 : (b == 8'hFF) ? 8'hFC : b;
  endfunction

  function automatic bit rise_at(int i);
    if (i < 0) return 1'b0;
    return s_line[i] && (i == 0 || !s_line[i-1]);
  endfunction

  function automatic bit vfall_at(int j);
    if (j < 1) return 1'b0;
    return !s_line[j] && s_line[j-1] && !s_kind[j-1];
  endfunction

  task automatic gen(int unsigned sd);
    int pos;
    seed = sd;
    for (int i = 0; i < N; i++) begin
      s_line[i] = 1'b0; s_kind[i] = rnd() % 2 == 0; s_vld[i] = rnd() % 2 == 0;
      s_data[i] = rbyte(); s_f[i] = 1'b0; s_v[i] = 1'b0;
    end
    pos = 0;
    while (1) begin
      int gap, len;
      bit k, f, v;
      gap = 8 + int'(rnd() % 5);
      k   = (rnd() % 3) == 0;
      len = k ? 2 + int'(rnd() % 6) : 1 + int'(rnd() % 14);
      f   = rnd() % 2 == 0;
      v   = rnd() % 2 == 0;
      if (pos + gap + len + 12 > N) break;
      for (int i = pos; i < pos + gap + len; i++) begin
        s_f[i] = f; s_v[i] = v;
      end
      pos += gap;
      for (int i = pos; i < pos + len; i++) begin
        s_line[i] = 1'b1; s_kind[i] = k;
        s_vld[i]  = k ? 1'b1 : ((rnd() % 4) != 0);
      end
      pos += len;
    end
  endtask

  task automatic apply(int i);
    in_line = s_line[i]; in_anc = s_kind[i]; in_vld = s_vld[i];
    in_data = s_data[i]; in_fld = s_f[i]; in_vblk = s_v[i];
  endtask

  task automatic check(string req, int cyc, logic [7:0] ab, bit adq, logic [7:0] eb, bit edq);
    checks++;
    if (ab !== eb || adq !== edq) begin
      errors++;
      $display("FAIL %s cycle %0d actual %h/%b expected %h/%b", req, cyc, ab, adq, eb, edq);
    end
  endtask

  task automatic expect_at(int k, output logic [7:0] eb, output bit act, output string req);
    eb = 8'h00; act = 1'b0; req = "R6";
    if (k >= 4 && !s_line[k-4] && s_vld[k-4]) req = "R5";
    for (int d = 0; d < 4; d++) begin
      if (rise_at(k - d) && !s_kind[k-d]) begin
        act = 1'b1;
        eb  = (d == 0) ? 8'hFF : (d == 3) ? tb_xy(s_f[k-d], s_v[k-d], 1'b0) : 8'h00;
        req = (d == 3) ? "R4" : "R2";
        return;
      end
      if (d < 3 && rise_at(k - d) && s_kind[k-d]) begin
        act = 1'b1; eb = (d == 0) ? 8'h00 : 8'hFF; req = "R9";
        return;
      end
      if (vfall_at(k - 4 - d)) begin
        act = 1'b1;
        eb  = (d == 0) ? 8'hFF : (d == 3) ? tb_xy(s_f[k-5-d], s_v[k-5-d], 1'b1) : 8'h00;
        req = "R3";
        return;
      end
    end
    if (k >= 4 && s_line[k-4] && !s_kind[k-4] && s_vld[k-4]) begin
      act = 1'b1; eb = tb_vid(s_data[k-4]); req = cfg_lim_en ? "R8" : "R7";
      return;
    end
    if (k >= 3 && s_line[k-3] && s_kind[k-3] && s_vld[k-3]) begin
      act = 1'b1; eb = tb_anc(s_data[k-3]); req = cfg_anc_recode ? "R10" : "R9";
    end
  endtask

  task automatic run_scenario(int unsigned sd, bit rec, bit lim, bit dqi, bit hi, bit vi);
    bit cur_v;
    cfg_anc_recode = rec; cfg_lim_en = lim; cfg_dq_inv = dqi;
    cfg_href_inv = hi; cfg_vref_inv = vi;
    gen(sd);
    @(negedge clk);
    rst_n = 1'b0;
    in_line = 1'b0; in_vld = 1'b1; in_data = 8'hFF;
    repeat (3) begin
      @(negedge clk);
      // R1: reset levels at the ports.
      check("R1", -1, out_data, out_dq, 8'h00, dqi);
      check("R1", -1, 8'h00, out_href, 8'h00, hi);
      check("R1", -1, 8'h00, out_vref, 8'h00, vi);
    end
    rst_n = 1'b1;
    apply(0);
    for (int k = 0; k < N; k++) begin
      @(posedge clk);
      @(negedge clk);
      o_b[k] = out_data; o_dq[k] = out_dq; o_h[k] = out_href; o_vr[k] = out_vref;
      if (k + 1 < N) apply(k + 1);
    end
    cur_v = 1'b0;
    for (int k = 0; k < N; k++) begin
      logic [7:0] eb;
      bit act, eh;
      string req;
      expect_at(k, eb, act, req);
      check(req, k, o_b[k], o_dq[k], eb, act ^ dqi);
      eh = (k >= 4) ? (s_line[k-4] && !s_kind[k-4]) : 1'b0;
      check("R12", k, 8'h00, o_h[k], 8'h00, eh ^ hi);
      if (rise_at(k)) cur_v = s_v[k];
      check("R11", k, 8'h00, o_vr[k], 8'h00, cur_v ^ vi);
    end
  endtask

  initial begin
    run_scenario(32'd11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    cfg_lim_lo = 8'h10; cfg_lim_hi = 8'hEB;
    run_scenario(32'd2024, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    cfg_lim_lo = 8'h40; cfg_lim_hi = 8'hC0;
    run_scenario(32'd777, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    run_scenario(32'd31337, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog cycle limit actual 20000 expected fewer");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule